// File: doc/BRIEF.md
# Framed Transmit Queue with Arbiter Request

This block holds outgoing data frames for a serial link until a link arbiter lets them go. A frame is offered as a header strobe, then one payload word per valid cycle. The header carries a 3-bit payload size and a 2-bit channel type. Headers go into a four-entry header FIFO and payload words into a 32-word data FIFO. The two are linked frame by frame. A frame counts as queued only after its last payload word has been stored. The header is committed at that moment, so the number of stored headers is the number of queued frames.

While all three enables are high and at least one frame is queued, the block raises a request to the arbiter. A grant starts a frame. The block sends one header beat, then the payload words in order, one per cycle, to the serializer side. The final word is flagged, the frame counter drops by one, and a sticky done flag is set. If a grant arrives on the final word while further frames wait, the next header follows with no idle cycle. A frame offered without room for all of it in both FIFOs is refused, and a sticky error flag is set.

The loader has two states. `L_IDLE` moves to `L_LOAD` on an accepted start, and stays in `L_IDLE` on a refused start. `L_LOAD` returns to `L_IDLE` on the final payload word. The sender has three states. `S_IDLE` moves to `S_HDR` when a request is granted. `S_HDR` always moves to `S_PAY`. `S_PAY` leaves on its final word: it goes to `S_HDR` when a grant is present, the enables are high and another frame waits; otherwise it goes to `S_IDLE`.

Top module: `txframe_queue`

## Requirements
- R1: After reset, `arb_req`, `out_valid`, `tx_done` and `push_err` are 0 and `frame_cnt` is 0.
- R2: The `in_start` cycle presents the header. `in_size` encodes size+1 payload words (0 means 1 word, 7 means 8 words). In the following cycles, each `in_word_valid` stores one word. `frame_cnt` rises by one in the cycle after the final word is stored, not earlier.
- R3: `arb_req` is 1 exactly when `en_data`, `en_tx` and `en_path` are all 1 and `frame_cnt` is nonzero.
- R4: While any enable is 0, no frame starts. Queued frames stay queued and keep their count.
- R5: When a request is granted while the block is idle, the next cycle carries a header beat: `out_valid`=1, `out_hdr`=1, `out_last`=0. In that beat `out_data[2:0]` is the size code, `out_data[4:3]` is the channel type and the upper bits are 0. The payload words follow, one per cycle in push order, with `out_last`=1 only on the final word.
- R6: If a grant arrives on a final payload word, the enables are high and another frame is queued, that frame's header beat appears in the very next cycle.
- R7: `frame_cnt` falls by one on each final payload word sent, and is never 0 while a beat is being sent.
- R8: `tx_done` is set in the cycle after each final payload word. It stays set until a cycle with `done_clr`=1, and a new frame end in that same cycle wins.
- R9: A start is refused if the header FIFO is full or the data FIFO has fewer free words than the frame needs. A refused frame stores nothing, and its words are ignored. `push_err` is then set and stays set until `err_clr`. A frame that exactly fills the free space is accepted.
- R10: A grant is acted on only while idle or on a final payload word. Grants at any other time neither repeat nor restart a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_data | input | 1 | Data-channel enable |
| en_tx | input | 1 | Transmit enable |
| en_path | input | 1 | FIFO/data-path enable |
| in_start | input | 1 | Header strobe beginning a frame |
| in_size | input | 3 | Payload size code (words minus one) |
| in_chan | input | 2 | Channel type |
| in_word_valid | input | 1 | Payload word strobe |
| in_word | input | 32 | Payload word |
| in_loading | output | 1 | Loader is collecting payload words |
| arb_req | output | 1 | Transmit request to arbiter |
| arb_gnt | input | 1 | Grant from arbiter |
| out_valid | output | 1 | Beat valid toward serializer |
| out_hdr | output | 1 | Beat is a header |
| out_last | output | 1 | Beat is the final payload word |
| out_data | output | 32 | Beat contents |
| frame_cnt | output | 3 | Complete frames queued |
| done_clr | input | 1 | Clear for tx_done |
| tx_done | output | 1 | Sticky frame-sent flag |
| err_clr | input | 1 | Clear for push_err |
| push_err | output | 1 | Sticky refused-push flag |

## Verification
The bound checker watches several rules on every cycle. The request must follow the enables and the count. Nothing may start while an enable is low. A granted idle cycle must lead into a header beat. Every final word must lower the count and set the done flag. A refusal must raise the error flag, and a header may never be committed into a full FIFO. Only the bench's scenarios can show the rest. That covers the payload order and header field layout seen by the scoreboard, and the exact-fit boundary against a fifth refused frame. It also covers the words of a refused frame being dropped, and the header of a following frame arriving with no gap cycle.

// File: rtl/txfq_pkg.sv
package txfq_pkg;

    parameter int SIZE_W = 3;
    parameter int CHAN_W = 2;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [SIZE_W-1:0] size;
    } hdr_t;

    localparam int HDR_W = $bits(hdr_t);

    typedef enum logic {
        L_IDLE,
        L_LOAD
    } load_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HDR,
        S_PAY
    } send_state_t;

endpackage

// File: rtl/txfq_fifo.sv
module txfq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/txfq_loader.sv
module txfq_loader
    import txfq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int HDR_DEPTH  = 4,
    parameter int DATA_DEPTH = 32,
    localparam int HCW = $clog2(HDR_DEPTH + 1),
    localparam int DCW = $clog2(DATA_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIZE_W-1:0] size,
    input  logic [CHAN_W-1:0] chan,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word,
    input  logic [HCW-1:0]    hdr_count,
    input  logic [DCW-1:0]    data_count,
    output logic              loading,
    output logic              data_push,
    output logic [DATA_W-1:0] data_wdata,
    output logic              hdr_push,
    output hdr_t              hdr_wdata,
    output logic              reject
);

    load_state_t       state;
    load_state_t       state_nx;
    hdr_t              hdr_q;
    logic [SIZE_W-1:0] beat_q;
    logic              fits;
    logic              final_word;
    logic [31:0]       free_words;
    logic [31:0]       need_words;

    always_comb begin
        free_words = 32'(DATA_DEPTH) - 32'(data_count);
        need_words = 32'(size) + 32'd1;
        fits       = (hdr_count < HCW'(HDR_DEPTH)) && (need_words <= free_words);
        final_word = word_valid && (beat_q == hdr_q.size);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            L_IDLE: if (start && fits) state_nx = L_LOAD;
            L_LOAD: if (final_word)    state_nx = L_IDLE;
            default:                   state_nx = L_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= L_IDLE;
            hdr_q  <= '0;
            beat_q <= '0;
        end else begin
            state <= state_nx;
            if (state == L_IDLE && start && fits) begin
                hdr_q  <= '{chan: chan, size: size};
                beat_q <= '0;
            end else if (state == L_LOAD && word_valid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        loading    = 1'b0;
        data_push  = 1'b0;
        hdr_push   = 1'b0;
        reject     = 1'b0;
        data_wdata = word;
        hdr_wdata  = hdr_q;
        unique case (state)
            L_IDLE: begin
                reject = start && !fits;
            end
            L_LOAD: begin
                loading   = 1'b1;
                data_push = word_valid;
                hdr_push  = final_word;
            end
            default: begin
                loading = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/txfq_sender.sv
module txfq_sender
    import txfq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int HDR_DEPTH = 4,
    localparam int HCW = $clog2(HDR_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              gnt,
    input  logic [HCW-1:0]    frame_cnt,
    input  hdr_t              hdr,
    input  logic [DATA_W-1:0] data,
    output logic              req,
    output logic              out_valid,
    output logic              out_hdr,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data,
    output logic              data_pop,
    output logic              hdr_pop,
    output logic              done_set
);

    send_state_t       state;
    send_state_t       state_nx;
    logic [SIZE_W-1:0] beat_q;
    logic              last_beat;
    logic              chain;

    always_comb begin
        last_beat = (state == S_PAY) && (beat_q == hdr.size);
        chain     = gnt && run && (frame_cnt > HCW'(1));
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (req && gnt) state_nx = S_HDR;
            S_HDR:  state_nx = S_PAY;
            S_PAY:  if (last_beat)  state_nx = chain ? S_HDR : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            beat_q <= '0;
        end else begin
            state <= state_nx;
            if (state == S_HDR) begin
                beat_q <= '0;
            end else if (state == S_PAY) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        req       = run && (frame_cnt != '0);
        out_valid = 1'b0;
        out_hdr   = 1'b0;
        out_last  = 1'b0;
        out_data  = '0;
        data_pop  = 1'b0;
        hdr_pop   = 1'b0;
        done_set  = 1'b0;
        unique case (state)
            S_IDLE: begin
                out_valid = 1'b0;
            end
            S_HDR: begin
                out_valid = 1'b1;
                out_hdr   = 1'b1;
                out_data  = DATA_W'(hdr);
            end
            S_PAY: begin
                out_valid = 1'b1;
                out_data  = data;
                data_pop  = 1'b1;
                out_last  = last_beat;
                hdr_pop   = last_beat;
                done_set  = last_beat;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/txframe_queue.sv
module txframe_queue
    import txfq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int HDR_DEPTH  = 4,
    parameter int DATA_DEPTH = 32,
    localparam int HCW = $clog2(HDR_DEPTH + 1),
    localparam int DCW = $clog2(DATA_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_data,
    input  logic              en_tx,
    input  logic              en_path,
    input  logic              in_start,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic              in_word_valid,
    input  logic [DATA_W-1:0] in_word,
    output logic              in_loading,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              out_valid,
    output logic              out_hdr,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data,
    output logic [HCW-1:0]    frame_cnt,
    input  logic              done_clr,
    output logic              tx_done,
    input  logic              err_clr,
    output logic              push_err
);

    logic              run;
    logic              ld_data_push;
    logic [DATA_W-1:0] ld_data_wdata;
    logic              ld_hdr_push;
    hdr_t              ld_hdr_wdata;
    logic              ld_reject;
    logic              sd_data_pop;
    logic              sd_hdr_pop;
    logic              sd_done_set;
    logic [HDR_W-1:0]  hq_rdata;
    logic [DATA_W-1:0] dq_rdata;
    logic [DCW-1:0]    dq_count;

    assign run = en_data && en_tx && en_path;

    txfq_fifo #(
        .WIDTH (HDR_W),
        .DEPTH (HDR_DEPTH)
    ) u_hdr_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ld_hdr_push),
        .wdata (ld_hdr_wdata),
        .pop   (sd_hdr_pop),
        .rdata (hq_rdata),
        .count (frame_cnt)
    );

    txfq_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (DATA_DEPTH)
    ) u_data_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ld_data_push),
        .wdata (ld_data_wdata),
        .pop   (sd_data_pop),
        .rdata (dq_rdata),
        .count (dq_count)
    );

    txfq_loader #(
        .DATA_W     (DATA_W),
        .HDR_DEPTH  (HDR_DEPTH),
        .DATA_DEPTH (DATA_DEPTH)
    ) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (in_start),
        .size       (in_size),
        .chan       (in_chan),
        .word_valid (in_word_valid),
        .word       (in_word),
        .hdr_count  (frame_cnt),
        .data_count (dq_count),
        .loading    (in_loading),
        .data_push  (ld_data_push),
        .data_wdata (ld_data_wdata),
        .hdr_push   (ld_hdr_push),
        .hdr_wdata  (ld_hdr_wdata),
        .reject     (ld_reject)
    );

    txfq_sender #(
        .DATA_W    (DATA_W),
        .HDR_DEPTH (HDR_DEPTH)
    ) u_sender (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .gnt       (arb_gnt),
        .frame_cnt (frame_cnt),
        .hdr       (hdr_t'(hq_rdata)),
        .data      (dq_rdata),
        .req       (arb_req),
        .out_valid (out_valid),
        .out_hdr   (out_hdr),
        .out_last  (out_last),
        .out_data  (out_data),
        .data_pop  (sd_data_pop),
        .hdr_pop   (sd_hdr_pop),
        .done_set  (sd_done_set)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done  <= 1'b0;
            push_err <= 1'b0;
        end else begin
            tx_done  <= sd_done_set || (tx_done && !done_clr);
            push_err <= ld_reject || (push_err && !err_clr);
        end
    end

endmodule

// File: rtl/txfq_checker.sv
module txfq_checker #(
    parameter int HDR_DEPTH = 4,
    parameter int HCW       = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en_data,
    input logic           en_tx,
    input logic           en_path,
    input logic           arb_req,
    input logic           arb_gnt,
    input logic           out_valid,
    input logic           out_hdr,
    input logic           out_last,
    input logic [HCW-1:0] frame_cnt,
    input logic           tx_done,
    input logic           push_err,
    input logic           ld_reject,
    input logic           ld_hdr_push
);

    logic all_on;
    assign all_on = en_data && en_tx && en_path;

    p_req_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !all_on |-> !arb_req);

    p_req_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt == '0) |-> !arb_req);

    p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !all_on) |=> !out_valid);

    p_hdr_after_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && arb_req && arb_gnt) |=> (out_valid && out_hdr));

    p_hdr_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_hdr |-> (out_valid && !out_last));

    p_count_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && !ld_hdr_push) |=> (frame_cnt == $past(frame_cnt) - 1'b1));

    p_busy_counted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (frame_cnt != '0));

    p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> tx_done);

    p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_reject |=> push_err);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hdr_push |-> (frame_cnt < HCW'(HDR_DEPTH)));

endmodule

bind txframe_queue txfq_checker #(
    .HDR_DEPTH (HDR_DEPTH),
    .HCW       (HCW)
) u_txfq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_data     (en_data),
    .en_tx       (en_tx),
    .en_path     (en_path),
    .arb_req     (arb_req),
    .arb_gnt     (arb_gnt),
    .out_valid   (out_valid),
    .out_hdr     (out_hdr),
    .out_last    (out_last),
    .frame_cnt   (frame_cnt),
    .tx_done     (tx_done),
    .push_err    (push_err),
    .ld_reject   (ld_reject),
    .ld_hdr_push (ld_hdr_push)
);

// File: tb/txframe_queue_bench.sv
module txframe_queue_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_data, en_tx, en_path;
    logic        in_start;
    logic [2:0]  in_size;
    logic [1:0]  in_chan;
    logic        in_word_valid;
    logic [31:0] in_word;
    logic        in_loading;
    logic        arb_req;
    logic        arb_gnt;
    logic        out_valid, out_hdr, out_last;
    logic [31:0] out_data;
    logic [2:0]  frame_cnt;
    logic        done_clr, tx_done, err_clr, push_err;

    logic        grant_on;
    int          checks   = 0;
    int          failures = 0;
    int          beats    = 0;
    int          b2b      = 0;
    int          cyc      = 0;
    logic        prev_last = 1'b0;
    logic [33:0] exp_q[$];

    always #5 clk = ~clk;

    assign arb_gnt = arb_req && grant_on;

    txframe_queue u_txframe_queue (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_data       (en_data),
        .en_tx         (en_tx),
        .en_path       (en_path),
        .in_start      (in_start),
        .in_size       (in_size),
        .in_chan       (in_chan),
        .in_word_valid (in_word_valid),
        .in_word       (in_word),
        .in_loading    (in_loading),
        .arb_req       (arb_req),
        .arb_gnt       (arb_gnt),
        .out_valid     (out_valid),
        .out_hdr       (out_hdr),
        .out_last      (out_last),
        .out_data      (out_data),
        .frame_cnt     (frame_cnt),
        .done_clr      (done_clr),
        .tx_done       (tx_done),
        .err_clr       (err_clr),
        .push_err      (push_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Monitor: pops the scoreboard for every beat sent (R5, R10)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            beats++;
            if (out_hdr && prev_last) b2b++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected beat", {31'b0, out_hdr, out_last, out_data}, 64'h0);
            end else begin
                logic [33:0] e;
                e = exp_q.pop_front();
                chk({out_hdr, out_last, out_data} == e, "R5 beat",
                    {30'b0, out_hdr, out_last, out_data}, {30'b0, e});
            end
        end
        prev_last <= rst_n && out_valid && out_last;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'h0);
            report();
        end
    end

    task automatic push_frame(input logic [2:0] sz, input logic [1:0] ch,
                              input logic [31:0] base, input bit accept);
        @(negedge clk);
        in_start = 1'b1;
        in_size  = sz;
        in_chan  = ch;
        if (accept) exp_q.push_back({1'b1, 1'b0, 27'b0, ch, sz});
        @(negedge clk);
        in_start = 1'b0;
        for (int i = 0; i <= int'(sz); i++) begin
            in_word_valid = 1'b1;
            in_word       = base + 32'(i);
            if (accept) exp_q.push_back({1'b0, 1'(i == int'(sz)), base + 32'(i)});
            @(negedge clk);
        end
        in_word_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; en_data = 1'b0; en_tx = 1'b0; en_path = 1'b0;
        in_start = 1'b0; in_size = '0; in_chan = '0; in_word_valid = 1'b0; in_word = '0;
        done_clr = 1'b0; err_clr = 1'b0; grant_on = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(!arb_req && !out_valid, "R1 req/valid", {arb_req, out_valid}, 0);
        chk(frame_cnt == 0, "R1 count", 64'(frame_cnt), 0);
        chk(!tx_done && !push_err, "R1 flags", {tx_done, push_err}, 0);

        // Queue while data-channel enable is off
        en_tx = 1'b1; en_path = 1'b1;
        push_frame(3'd2, 2'd1, 32'hA000_0000, 1'b1);
        chk(frame_cnt == 1, "R2 count after frame", 64'(frame_cnt), 1);
        push_frame(3'd0, 2'd2, 32'hB000_0000, 1'b1);
        chk(frame_cnt == 2, "R2 count after second", 64'(frame_cnt), 2);
        chk(!arb_req, "R3 req low with en_data off", 64'(arb_req), 0);
        grant_on = 1'b1;
        idle(10);
        chk(beats == 0, "R4 nothing sent while disabled", 64'(beats), 0);
        chk(frame_cnt == 2, "R4 frames held", 64'(frame_cnt), 2);

        // Enable, request without grant
        grant_on = 1'b0;
        en_data  = 1'b1;
        idle(1);
        chk(arb_req, "R3 req high", 64'(arb_req), 1);
        idle(5);
        chk(beats == 0, "R10 no grant no beats", 64'(beats), 0);

        grant_on = 1'b1;
        idle(20);
        chk(beats == 6, "R5 beat total", 64'(beats), 6);
        chk(exp_q.size() == 0, "R5 scoreboard drained", 64'(exp_q.size()), 0);
        chk(b2b == 1, "R6 back-to-back header", 64'(b2b), 1);
        chk(frame_cnt == 0, "R7 count down", 64'(frame_cnt), 0);
        chk(tx_done, "R8 done set", 64'(tx_done), 1);
        chk(!arb_req, "R3 req drops when empty", 64'(arb_req), 0);

        done_clr = 1'b1;
        idle(1);
        done_clr = 1'b0;
        chk(!tx_done, "R8 done cleared", 64'(tx_done), 0);

        // Fill both FIFOs exactly, then refuse a fifth frame
        grant_on = 1'b0;
        for (int f = 0; f < 4; f++) push_frame(3'd7, 2'(f), 32'h1000_0000 * (f + 1), 1'b1);
        chk(frame_cnt == 4, "R9 exact fit accepted", 64'(frame_cnt), 4);
        chk(!push_err, "R9 no error on exact fit", 64'(push_err), 0);
        push_frame(3'd0, 2'd3, 32'hDEAD_0000, 1'b0);
        chk(push_err, "R9 error on refused push", 64'(push_err), 1);
        chk(frame_cnt == 4, "R9 count unchanged", 64'(frame_cnt), 4);
        err_clr = 1'b1;
        idle(1);
        err_clr = 1'b0;
        chk(!push_err, "R9 error cleared", 64'(push_err), 0);

        // Transmit enable off holds the queue
        en_tx = 1'b0;
        idle(1);
        chk(!arb_req, "R3 req low with en_tx off", 64'(arb_req), 0);
        grant_on = 1'b1;
        idle(10);
        chk(beats == 6, "R4 held while en_tx off", 64'(beats), 6);
        en_tx = 1'b1;
        idle(45);
        chk(beats == 42, "R5 all beats sent", 64'(beats), 42);
        chk(exp_q.size() == 0, "R9 refused words never sent", 64'(exp_q.size()), 0);
        chk(b2b == 4, "R6 chained frames", 64'(b2b), 4);
        chk(frame_cnt == 0, "R7 drained", 64'(frame_cnt), 0);
        chk(tx_done, "R8 done after chain", 64'(tx_done), 1);
        report();
    end

endmodule